// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This block brings a combined USB2/USB3 PHY and its controller out of power-down in a safe order, and puts the PHY back into reset later. A one-cycle start request clears every control output to its power-down value and asserts all reset lines. The block then sets up the reference clock, lifts the low-power modes, releases the PHY resets and reports stable power. It configures the type-C adapter and spread-spectrum, releases the controller, and forces the VBUS-valid indications. Fixed waits, measured in system clocks, separate the steps that need settling time.

The last step tunes the PHY transmitter over a sideband control-register bus. The block acts as the requesting master: it reads the boost register, ORs in the enable bit and the boost level, and writes the result back. A read that times out is reissued up to a bounded number of attempts. Any other bus error, a write error, or running out of attempts sets a sticky error flag, and the next start request clears it.

A stop request puts the two PHY resets back into reset and then turns off the reference clock enable that matches the selected clock source. All waits, widths, the register address, the field positions, the boost level and the attempt count are parameters.

Top module: `usbphy_pwrseq`

## Requirements
- R1: While and after reset, all four reset outputs are 0 (reset active), `u2_iddq` and `u3_test_pd` are 1, every other control output is 0, and `busy`, `ready`, `err` and `cr_req` are 0.
- R2: A start request accepted while not busy drives all four reset outputs to 0, returns every other control output to its R1 value and raises `busy`, all on the first clock edge.
- R3: On the next edge, with `pad_clk_sel`=1 the block sets `refsel_pad` and `u2ref_gate_en`. With `pad_clk_sel`=0 it sets `xtal_en` and leaves `refsel_pad` at 0. `xtal_en` and `u2ref_gate_en` are never both 1.
- R4: On three consecutive edges after the clock step, `u2_iddq` falls, then `u3_test_pd` falls, then `rst_u3phy_n` and `rst_u2por_n` rise together.
- R5: `ana_pwr_en`, `pcs_stable` and `pma_stable` rise together exactly WAIT+1 cycles after the PHY resets rise, where WAIT = CLK_PER_US*WAIT_US.
- R6: On three consecutive edges after power-stable, `adapter_en` rises, then `ssc_en` rises, then `rst_aux_n` and `rst_ctrl_n` rise together.
- R7: The four VBUS override outputs rise together WAIT+1 cycles after the controller reset release. The first bus request rises WAIT+1 cycles after that.
- R8: A bus request holds `cr_req`=1 with stable `cr_we` and `cr_addr` (=BOOST_ADDR, 0x00F by default) until a cycle with `cr_ack`=1. `cr_req` is 0 in the cycle after the acknowledge. Reads use `cr_we`=0.
- R9: A read acknowledged with `cr_status`=2'b01 (timeout) is reissued. After MAX_READS (3) timed-out reads, `err` rises, `busy` falls and no write is issued.
- R10: A read acknowledged with `cr_status`=2'b10 or 2'b11, or a write acknowledged with a nonzero status, ends the sequence with `err`=1 and no retry.
- R11: After a read acknowledged with status 2'b00, one write is issued with `cr_we`=1 and `cr_wdata` = read data | bit 9 | (BOOST_LVL << 6), which is 0x0340 for the default level 5. A write acknowledged with status 2'b00 ends with `ready`=1, `busy`=0 and `err`=0.
- R12: A stop request accepted while not busy drives `rst_u3phy_n` and `rst_u2por_n` to 0 on the first edge. On the second edge it clears `u2ref_gate_en` (if `pad_clk_sel`=1) or `xtal_en` (if 0). All other control outputs keep their values, and `ready` is 0 afterwards.
- R13: When start and stop are requested in the same cycle, the start is taken and the stop is ignored. Both requests are ignored while `busy` is 1.
- R14: `err` stays 1 through stops and idle time until the next accepted start, which clears it on its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Start the power-up sequence |
| stop_req | input | 1 | Start the shut-down sequence |
| pad_clk_sel | input | 1 | 1: pad reference clock, 0: internal crystal clock |
| rst_aux_n | output | 1 | Auxiliary reset, active low |
| rst_ctrl_n | output | 1 | Controller reset, active low |
| rst_u3phy_n | output | 1 | USB3 PHY reset, active low |
| rst_u2por_n | output | 1 | USB2 PHY power-on reset, active low |
| u2_iddq | output | 1 | USB2 PHY IDDQ low-power mode |
| u3_test_pd | output | 1 | USB3 PHY test power-down |
| refsel_pad | output | 1 | Reference select: pad clock |
| u2ref_gate_en | output | 1 | USB2 PHY reference clock gate enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| ana_pwr_en | output | 1 | PHY analog power enable |
| pcs_stable | output | 1 | PCS power stable |
| pma_stable | output | 1 | PMA power stable |
| adapter_en | output | 1 | Type-C adapter configured for USB mode |
| ssc_en | output | 1 | PLL spread-spectrum enable |
| vbus_u3 | output | 1 | USB3 VBUS-valid override value |
| vbus_u3_sel | output | 1 | USB3 VBUS-valid override select |
| vbus_u2 | output | 1 | USB2 external VBUS-valid override value |
| vbus_u2_sel | output | 1 | USB2 external VBUS-valid override select |
| cr_req | output | 1 | Control-register bus request |
| cr_we | output | 1 | Request is a write |
| cr_addr | output | CR_AW | Register address |
| cr_wdata | output | CR_DW | Write data |
| cr_ack | input | 1 | Request completed |
| cr_status | input | 2 | 00 ok, 01 timeout, 10/11 error |
| cr_rdata | input | CR_DW | Read data, valid with cr_ack |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | Power-up completed without error |
| err | output | 1 | Sticky sequence error |

## Verification
A start and a stop can be requested in the same cycle, and so can a stop and an ongoing sequence. The bench raises both requests on one edge after a finished power-up. It then checks that the auxiliary reset drops, which a stop alone would leave released, and that the sequence completes. The bench also pulses stop in the middle of a wait and requires the run to end ready with the PHY resets still released. A sweep over both clock sources and zero to three read timeouts checks every step's cycle offset, the attempt count and the written word against values computed from the requirements.

// File: rtl/usbphy_pwrseq_pkg.sv
package usbphy_pwrseq_pkg;

   typedef enum logic [4:0] {
      S_IDLE, S_CLK, S_IDDQ, S_TPD, S_PREL, S_WAIT1, S_PWR, S_TCA,
      S_SSC, S_CREL, S_WAIT2, S_VBUS, S_WAIT3, S_RMW, S_READY, S_FAULT,
      S_STOP_RST, S_STOP_CLK
   } seq_state_e;

   typedef enum logic [3:0] {
      A_HOLD, A_DEFAULT, A_CLKCFG, A_IDDQ, A_TPD, A_PHYREL, A_PWR,
      A_TCA, A_SSC, A_CTRLREL, A_VBUS, A_STOPRST, A_STOPCLK
   } seq_act_e;

   typedef enum logic [2:0] {
      E_IDLE, E_RD, E_RSET, E_WSET, E_WR, E_FIN
   } rmw_state_e;

   localparam logic [1:0] CR_OK      = 2'b00;
   localparam logic [1:0] CR_TIMEOUT = 2'b01;

   typedef struct packed {
      logic rst_aux_n;
      logic rst_ctrl_n;
      logic rst_u3phy_n;
      logic rst_u2por_n;
      logic u2_iddq;
      logic u3_test_pd;
      logic refsel_pad;
      logic u2ref_gate_en;
      logic xtal_en;
      logic ana_pwr_en;
      logic pcs_stable;
      logic pma_stable;
      logic adapter_en;
      logic ssc_en;
      logic vbus_u3;
      logic vbus_u3_sel;
      logic vbus_u2;
      logic vbus_u2_sel;
   } phy_ctl_t;

   function automatic phy_ctl_t ctl_default();
      phy_ctl_t c;
      c            = '0;
      c.u2_iddq    = 1'b1;
      c.u3_test_pd = 1'b1;
      return c;
   endfunction

endpackage

// File: rtl/pwrseq_wait_timer.sv
module pwrseq_wait_timer #(
   parameter int CYCLES = 100,
   parameter int CNT_W  = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   logic [CNT_W-1:0] cnt;

   assign expired = run && (cnt == CNT_W'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (run && !expired)
         cnt <= cnt + 1'b1;
      else
         cnt <= '0;
   end
endmodule

// File: rtl/pwrseq_cr_rmw.sv
module pwrseq_cr_rmw
   import usbphy_pwrseq_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int ADDR      = 15,
   parameter logic [DW-1:0] SET_MASK = '0,
   parameter int MAX_READS = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   output logic          done,
   output logic          fail,
   output logic          cr_req,
   output logic          cr_we,
   output logic [AW-1:0] cr_addr,
   output logic [DW-1:0] cr_wdata,
   input  logic          cr_ack,
   input  logic [1:0]    cr_status,
   input  logic [DW-1:0] cr_rdata
);
   rmw_state_e    st;
   logic          req_q, we_q, fail_q;
   logic [DW-1:0] wdat_q;
   logic          last_try, try_clr, try_inc;

   assign try_clr = (st == E_IDLE);
   assign try_inc = (st == E_RD) && cr_ack && (cr_status == CR_TIMEOUT);

   generate
      if (MAX_READS > 1) begin : g_retry
         localparam int RW = $clog2(MAX_READS);
         logic [RW-1:0] tries;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tries <= '0;
            else if (try_clr)
               tries <= '0;
            else if (try_inc)
               tries <= tries + 1'b1;
         end
         assign last_try = (tries == RW'(MAX_READS - 1));
      end else begin : g_single
         assign last_try = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= E_IDLE;
         req_q  <= 1'b0;
         we_q   <= 1'b0;
         fail_q <= 1'b0;
         wdat_q <= '0;
      end else begin
         case (st)
            E_IDLE: if (go) begin
               st     <= E_RD;
               req_q  <= 1'b1;
               we_q   <= 1'b0;
               fail_q <= 1'b0;
            end
            E_RD: if (cr_ack) begin
               req_q <= 1'b0;
               if (cr_status == CR_OK) begin
                  wdat_q <= cr_rdata | SET_MASK;
                  st     <= E_WSET;
               end else if ((cr_status == CR_TIMEOUT) && !last_try) begin
                  st <= E_RSET;
               end else begin
                  fail_q <= 1'b1;
                  st     <= E_FIN;
               end
            end
            E_RSET: begin
               req_q <= 1'b1;
               st    <= E_RD;
            end
            E_WSET: begin
               req_q <= 1'b1;
               we_q  <= 1'b1;
               st    <= E_WR;
            end
            E_WR: if (cr_ack) begin
               req_q  <= 1'b0;
               we_q   <= 1'b0;
               fail_q <= (cr_status != CR_OK);
               st     <= E_FIN;
            end
            E_FIN: if (!go) st <= E_IDLE;
            default: st <= E_IDLE;
         endcase
      end
   end

   assign done     = (st == E_FIN);
   assign fail     = fail_q;
   assign cr_req   = req_q;
   assign cr_we    = we_q;
   assign cr_addr  = AW'(ADDR);
   assign cr_wdata = wdat_q;
endmodule

// File: rtl/pwrseq_ctl_regs.sv
module pwrseq_ctl_regs
   import usbphy_pwrseq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  seq_act_e act,
   input  logic     pad_sel,
   output phy_ctl_t ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= ctl_default();
      end else begin
         case (act)
            A_DEFAULT: ctl <= ctl_default();
            A_CLKCFG: begin
               if (pad_sel) begin
                  ctl.refsel_pad    <= 1'b1;
                  ctl.u2ref_gate_en <= 1'b1;
               end else begin
                  ctl.refsel_pad <= 1'b0;
                  ctl.xtal_en    <= 1'b1;
               end
            end
            A_IDDQ:   ctl.u2_iddq    <= 1'b0;
            A_TPD:    ctl.u3_test_pd <= 1'b0;
            A_PHYREL: begin
               ctl.rst_u3phy_n <= 1'b1;
               ctl.rst_u2por_n <= 1'b1;
            end
            A_PWR: begin
               ctl.ana_pwr_en <= 1'b1;
               ctl.pcs_stable <= 1'b1;
               ctl.pma_stable <= 1'b1;
            end
            A_TCA:    ctl.adapter_en <= 1'b1;
            A_SSC:    ctl.ssc_en     <= 1'b1;
            A_CTRLREL: begin
               ctl.rst_aux_n  <= 1'b1;
               ctl.rst_ctrl_n <= 1'b1;
            end
            A_VBUS: begin
               ctl.vbus_u3     <= 1'b1;
               ctl.vbus_u3_sel <= 1'b1;
               ctl.vbus_u2     <= 1'b1;
               ctl.vbus_u2_sel <= 1'b1;
            end
            A_STOPRST: begin
               ctl.rst_u3phy_n <= 1'b0;
               ctl.rst_u2por_n <= 1'b0;
            end
            A_STOPCLK: begin
               if (pad_sel) ctl.u2ref_gate_en <= 1'b0;
               else         ctl.xtal_en       <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/usbphy_pwrseq.sv
module usbphy_pwrseq
   import usbphy_pwrseq_pkg::*;
#(
   parameter int CLK_PER_US   = 250,
   parameter int WAIT_US      = 100,
   parameter int CR_AW        = 16,
   parameter int CR_DW        = 16,
   parameter int BOOST_ADDR   = 15,
   parameter int BOOST_LSB    = 6,
   parameter int BOOST_W      = 3,
   parameter int BOOST_LVL    = 5,
   parameter int BOOST_EN_BIT = 9,
   parameter int MAX_READS    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             pad_clk_sel,
   output logic             rst_aux_n,
   output logic             rst_ctrl_n,
   output logic             rst_u3phy_n,
   output logic             rst_u2por_n,
   output logic             u2_iddq,
   output logic             u3_test_pd,
   output logic             refsel_pad,
   output logic             u2ref_gate_en,
   output logic             xtal_en,
   output logic             ana_pwr_en,
   output logic             pcs_stable,
   output logic             pma_stable,
   output logic             adapter_en,
   output logic             ssc_en,
   output logic             vbus_u3,
   output logic             vbus_u3_sel,
   output logic             vbus_u2,
   output logic             vbus_u2_sel,
   output logic             cr_req,
   output logic             cr_we,
   output logic [CR_AW-1:0] cr_addr,
   output logic [CR_DW-1:0] cr_wdata,
   input  logic             cr_ack,
   input  logic [1:0]       cr_status,
   input  logic [CR_DW-1:0] cr_rdata,
   output logic             busy,
   output logic             ready,
   output logic             err
);
   localparam int WAIT_CYC = CLK_PER_US * WAIT_US;
   localparam int TMR_W    = $clog2(WAIT_CYC + 1);
   localparam logic [CR_DW-1:0] SET_MASK =
      (CR_DW'(1) << BOOST_EN_BIT) | (CR_DW'(BOOST_LVL) << BOOST_LSB);

   generate
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("wait must be at least one clock");
      end
      if (MAX_READS < 1) begin : g_bad_reads
         $error("at least one read attempt is needed");
      end
      if (BOOST_LSB + BOOST_W > CR_DW || BOOST_EN_BIT >= CR_DW) begin : g_bad_field
         $error("boost field exceeds the data width");
      end
      if (BOOST_LVL >= (1 << BOOST_W) || BOOST_LVL < 0) begin : g_bad_lvl
         $error("boost level does not fit its field");
      end
      if (CR_AW > 30 || BOOST_ADDR >= (1 << CR_AW)) begin : g_bad_addr
         $error("boost register address does not fit the address width");
      end
   endgenerate

   seq_state_e st, nxt;
   seq_act_e   act;
   phy_ctl_t   ctl;
   logic       idle_like, tmr_run, tmr_exp, rmw_go, rmw_done, rmw_fail;
   logic       err_q;

   assign idle_like = (st == S_IDLE) || (st == S_READY) || (st == S_FAULT);
   assign tmr_run   = (st == S_WAIT1) || (st == S_WAIT2) || (st == S_WAIT3);
   assign rmw_go    = (st == S_RMW);

   always_comb begin
      nxt = st;
      act = A_HOLD;
      case (st)
         S_IDLE, S_READY, S_FAULT: begin
            if (start_req) begin
               act = A_DEFAULT;
               nxt = S_CLK;
            end else if (stop_req) begin
               act = A_STOPRST;
               nxt = S_STOP_CLK;
            end
         end
         S_CLK:   begin act = A_CLKCFG;  nxt = S_IDDQ; end
         S_IDDQ:  begin act = A_IDDQ;    nxt = S_TPD;  end
         S_TPD:   begin act = A_TPD;     nxt = S_PREL; end
         S_PREL:  begin act = A_PHYREL;  nxt = S_WAIT1; end
         S_WAIT1: if (tmr_exp) nxt = S_PWR;
         S_PWR:   begin act = A_PWR;     nxt = S_TCA;  end
         S_TCA:   begin act = A_TCA;     nxt = S_SSC;  end
         S_SSC:   begin act = A_SSC;     nxt = S_CREL; end
         S_CREL:  begin act = A_CTRLREL; nxt = S_WAIT2; end
         S_WAIT2: if (tmr_exp) nxt = S_VBUS;
         S_VBUS:  begin act = A_VBUS;    nxt = S_WAIT3; end
         S_WAIT3: if (tmr_exp) nxt = S_RMW;
         S_RMW:   if (rmw_done) nxt = rmw_fail ? S_FAULT : S_READY;
         S_STOP_CLK: begin act = A_STOPCLK; nxt = S_IDLE; end
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         err_q <= 1'b0;
      end else begin
         st <= nxt;
         if (idle_like && start_req)
            err_q <= 1'b0;
         else if (rmw_go && rmw_done && rmw_fail)
            err_q <= 1'b1;
      end
   end

   pwrseq_wait_timer #(.CYCLES(WAIT_CYC), .CNT_W(TMR_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tmr_run),
      .expired (tmr_exp)
   );

   pwrseq_ctl_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .pad_sel (pad_clk_sel),
      .ctl     (ctl)
   );

   pwrseq_cr_rmw #(
      .AW        (CR_AW),
      .DW        (CR_DW),
      .ADDR      (BOOST_ADDR),
      .SET_MASK  (SET_MASK),
      .MAX_READS (MAX_READS)
   ) u_rmw (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (rmw_go),
      .done      (rmw_done),
      .fail      (rmw_fail),
      .cr_req    (cr_req),
      .cr_we     (cr_we),
      .cr_addr   (cr_addr),
      .cr_wdata  (cr_wdata),
      .cr_ack    (cr_ack),
      .cr_status (cr_status),
      .cr_rdata  (cr_rdata)
   );

   assign rst_aux_n     = ctl.rst_aux_n;
   assign rst_ctrl_n    = ctl.rst_ctrl_n;
   assign rst_u3phy_n   = ctl.rst_u3phy_n;
   assign rst_u2por_n   = ctl.rst_u2por_n;
   assign u2_iddq       = ctl.u2_iddq;
   assign u3_test_pd    = ctl.u3_test_pd;
   assign refsel_pad    = ctl.refsel_pad;
   assign u2ref_gate_en = ctl.u2ref_gate_en;
   assign xtal_en       = ctl.xtal_en;
   assign ana_pwr_en    = ctl.ana_pwr_en;
   assign pcs_stable    = ctl.pcs_stable;
   assign pma_stable    = ctl.pma_stable;
   assign adapter_en    = ctl.adapter_en;
   assign ssc_en        = ctl.ssc_en;
   assign vbus_u3       = ctl.vbus_u3;
   assign vbus_u3_sel   = ctl.vbus_u3_sel;
   assign vbus_u2       = ctl.vbus_u2;
   assign vbus_u2_sel   = ctl.vbus_u2_sel;
   assign busy          = !idle_like;
   assign ready         = (st == S_READY);
   assign err           = err_q;
endmodule

// File: rtl/usbphy_pwrseq_chk.sv
module usbphy_pwrseq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_req,
   input logic          stop_req,
   input logic          busy,
   input logic          ready,
   input logic          err,
   input logic          rst_aux_n,
   input logic          rst_ctrl_n,
   input logic          rst_u3phy_n,
   input logic          rst_u2por_n,
   input logic          xtal_en,
   input logic          u2ref_gate_en,
   input logic          pcs_stable,
   input logic          adapter_en,
   input logic          ssc_en,
   input logic          cr_req,
   input logic          cr_we,
   input logic [AW-1:0] cr_addr,
   input logic          cr_ack
);
   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy) |=> (!rst_aux_n && !rst_ctrl_n && !rst_u3phy_n && !rst_u2por_n && busy));

   // R3
   one_refclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(xtal_en && u2ref_gate_en));

   // R5
   pwr_after_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pcs_stable) |-> (rst_u3phy_n && rst_u2por_n));

   // R6
   ctrl_rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_ctrl_n) |-> (ssc_en && adapter_en));

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_req && !cr_ack) |=> (cr_req && $stable(cr_we) && $stable(cr_addr)));

   // R8
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_req && cr_ack) |=> !cr_req);

   // R12
   stop_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !start_req && !busy) |=> (!rst_u3phy_n && !rst_u2por_n));

   // R14
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!ready && !cr_req));
endmodule

bind usbphy_pwrseq usbphy_pwrseq_chk #(.AW(CR_AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_req     (start_req),
   .stop_req      (stop_req),
   .busy          (busy),
   .ready         (ready),
   .err           (err),
   .rst_aux_n     (rst_aux_n),
   .rst_ctrl_n    (rst_ctrl_n),
   .rst_u3phy_n   (rst_u3phy_n),
   .rst_u2por_n   (rst_u2por_n),
   .xtal_en       (xtal_en),
   .u2ref_gate_en (u2ref_gate_en),
   .pcs_stable    (pcs_stable),
   .adapter_en    (adapter_en),
   .ssc_en        (ssc_en),
   .cr_req        (cr_req),
   .cr_we         (cr_we),
   .cr_addr       (cr_addr),
   .cr_ack        (cr_ack)
);

// File: tb/usbphy_pwrseq_test.sv
`timescale 1ns/1ps
module usbphy_pwrseq_test;
   localparam int CPU = 4;
   localparam int WUS = 3;
   localparam int W   = CPU * WUS;
   localparam int LAT = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0, stop_req = 1'b0, pad_clk_sel = 1'b0;
   logic rst_aux_n, rst_ctrl_n, rst_u3phy_n, rst_u2por_n, u2_iddq, u3_test_pd;
   logic refsel_pad, u2ref_gate_en, xtal_en, ana_pwr_en, pcs_stable, pma_stable;
   logic adapter_en, ssc_en, vbus_u3, vbus_u3_sel, vbus_u2, vbus_u2_sel;
   logic cr_req, cr_we, busy, ready, err;
   logic [15:0] cr_addr, cr_wdata;
   logic cr_ack = 1'b0;
   logic [1:0] cr_status = 2'b00;
   logic [15:0] cr_rdata = 16'h0;

   int n_tests = 0, n_fail = 0, cyc = 0;
   logic [1:0] rsp [0:4];
   int rsp_idx = 0, n_rd = 0, n_wr = 0, lat = 0;
   logic [15:0] last_wdata = 16'h0;
   logic addr_bad = 1'b0;
   logic finished = 1'b0;

   always #2 clk = ~clk;

   usbphy_pwrseq #(.CLK_PER_US(CPU), .WAIT_US(WUS)) uut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
      .pad_clk_sel(pad_clk_sel), .rst_aux_n(rst_aux_n), .rst_ctrl_n(rst_ctrl_n),
      .rst_u3phy_n(rst_u3phy_n), .rst_u2por_n(rst_u2por_n), .u2_iddq(u2_iddq),
      .u3_test_pd(u3_test_pd), .refsel_pad(refsel_pad), .u2ref_gate_en(u2ref_gate_en),
      .xtal_en(xtal_en), .ana_pwr_en(ana_pwr_en), .pcs_stable(pcs_stable),
      .pma_stable(pma_stable), .adapter_en(adapter_en), .ssc_en(ssc_en),
      .vbus_u3(vbus_u3), .vbus_u3_sel(vbus_u3_sel), .vbus_u2(vbus_u2),
      .vbus_u2_sel(vbus_u2_sel), .cr_req(cr_req), .cr_we(cr_we), .cr_addr(cr_addr),
      .cr_wdata(cr_wdata), .cr_ack(cr_ack), .cr_status(cr_status), .cr_rdata(cr_rdata),
      .busy(busy), .ready(ready), .err(err)
   );

   // Bus responder: acknowledges each request LAT cycles after it is seen.
   initial begin
      forever begin
         @(negedge clk);
         if (cr_ack) begin
            cr_ack = 1'b0;
            lat = 0;
         end else if (cr_req) begin
            lat = lat + 1;
            if (cr_addr !== 16'h000F) addr_bad = 1'b1;
            if (lat == LAT) begin
               cr_status = rsp[rsp_idx];
               rsp_idx = rsp_idx + 1;
               if (cr_we) begin
                  n_wr = n_wr + 1;
                  last_wdata = cr_wdata;
               end else begin
                  n_rd = n_rd + 1;
               end
               cr_ack = 1'b1;
            end
         end else begin
            lat = 0;
         end
      end
   end

   task automatic tick();
      @(negedge clk);
      cyc = cyc + 1;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests = n_tests + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_rsp(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c,
                          input logic [1:0] d, input logic [1:0] e);
      rsp[0] = a; rsp[1] = b; rsp[2] = c; rsp[3] = d; rsp[4] = e;
      rsp_idx = 0; n_rd = 0; n_wr = 0; addr_bad = 1'b0;
   endtask

   // Start (optionally with a same-cycle stop), record the step cycles, run to the end.
   task automatic run_seq(input logic pad, input logic both, input logic inj_stop,
                          input logic timing);
      int t [0:9];
      int e [0:9];
      string nm [0:9];
      logic [9:0] c;
      for (int i = 0; i < 10; i++) t[i] = -1;
      pad_clk_sel = pad;
      start_req = 1'b1;
      stop_req = both;
      tick();
      start_req = 1'b0;
      stop_req = 1'b0;
      check("R2 resets asserted", {rst_aux_n, rst_ctrl_n, rst_u3phy_n, rst_u2por_n}, 4'b0000);
      check("R2 busy", busy, 1'b1);
      check("R2 defaults", {u2_iddq, u3_test_pd, ana_pwr_en, ssc_en, adapter_en, vbus_u3}, 6'b110000);
      check("R14 err cleared by start", err, 1'b0);
      for (int k = 1; k < 1000 && busy; k++) begin
         if (inj_stop && k == 20) stop_req = 1'b1;
         tick();
         stop_req = 1'b0;
         c = {cr_req, vbus_u3, rst_ctrl_n, ssc_en, adapter_en, pcs_stable,
              rst_u3phy_n, !u3_test_pd, !u2_iddq, (xtal_en || u2ref_gate_en)};
         for (int i = 0; i < 10; i++) if (c[i] && t[i] < 0) t[i] = k;
      end
      e[0] = 1;         nm[0] = "R3 clock step cycle";
      e[1] = 2;         nm[1] = "R4 iddq exit cycle";
      e[2] = 3;         nm[2] = "R4 test power-down exit cycle";
      e[3] = 4;         nm[3] = "R4 phy reset release cycle";
      e[4] = 5 + W;     nm[4] = "R5 power stable cycle";
      e[5] = 6 + W;     nm[5] = "R6 adapter cycle";
      e[6] = 7 + W;     nm[6] = "R6 ssc cycle";
      e[7] = 8 + W;     nm[7] = "R6 controller release cycle";
      e[8] = 9 + 2*W;   nm[8] = "R7 vbus override cycle";
      e[9] = 10 + 3*W;  nm[9] = "R7 first request cycle";
      if (timing)
         for (int i = 0; i < 10; i++) check(nm[i], t[i], e[i]);
   endtask

   task automatic do_stop(input logic pad);
      logic gate_before, xtal_before;
      gate_before = u2ref_gate_en;
      xtal_before = xtal_en;
      pad_clk_sel = pad;
      stop_req = 1'b1;
      tick();
      stop_req = 1'b0;
      check("R12 phy resets asserted", {rst_u3phy_n, rst_u2por_n}, 2'b00);
      check("R12 clock enables held one cycle", {u2ref_gate_en, xtal_en}, {gate_before, xtal_before});
      check("R12 controller reset unchanged", {rst_aux_n, rst_ctrl_n}, {2{ready === 1'b0 ? rst_ctrl_n : 1'b1}});
      tick();
      if (pad) check("R12 pad gate off", {u2ref_gate_en, refsel_pad}, 2'b01);
      else     check("R12 crystal off", {xtal_en, refsel_pad}, 2'b00);
      check("R12 idle, not ready", {busy, ready}, 2'b00);
   endtask

   initial begin
      logic [15:0] rd;
      for (int i = 0; i < 5; i++) rsp[i] = 2'b00;
      repeat (3) tick();
      check("R1 resets", {rst_aux_n, rst_ctrl_n, rst_u3phy_n, rst_u2por_n}, 4'b0000);
      check("R1 low-power modes", {u2_iddq, u3_test_pd}, 2'b11);
      check("R1 enables", {refsel_pad, u2ref_gate_en, xtal_en, ana_pwr_en, pcs_stable, pma_stable,
                           adapter_en, ssc_en, vbus_u3, vbus_u3_sel, vbus_u2, vbus_u2_sel}, 12'h000);
      check("R1 status", {busy, ready, err, cr_req}, 4'b0000);
      rst_n = 1'b1;
      tick();
      check("R1 after reset release", {busy, ready, err, cr_req, u2_iddq}, 5'b00001);

      // Sweep: both clock sources, zero to three read timeouts.
      for (int p = 0; p < 2; p++) begin
         for (int nto = 0; nto < 4; nto++) begin
            rd = 16'hA005 ^ 16'(nto << 3) ^ 16'(p << 12);
            cr_rdata = rd;
            set_rsp(nto > 0 ? 2'b01 : 2'b00, nto > 1 ? 2'b01 : 2'b00,
                    nto > 2 ? 2'b01 : 2'b00, 2'b00, 2'b00);
            run_seq(p[0], 1'b0, 1'b0, 1'b1);
            check("R8 address and read direction", addr_bad, 1'b0);
            if (nto < 3) begin
               check("R9 read attempts", n_rd, nto + 1);
               check("R11 one write", n_wr, 1);
               check("R11 write data", last_wdata, rd | 16'h0200 | 16'h0140);
               check("R11 ready", {ready, busy, err}, 3'b100);
               check("R5 trio", {ana_pwr_en, pcs_stable, pma_stable}, 3'b111);
               check("R7 vbus overrides", {vbus_u3, vbus_u3_sel, vbus_u2, vbus_u2_sel}, 4'hF);
            end else begin
               check("R9 read attempts on exhaustion", n_rd, 3);
               check("R9 no write", n_wr, 0);
               check("R9 error end", {ready, busy, err}, 3'b001);
            end
            if (p == 1) check("R3 pad clock", {refsel_pad, u2ref_gate_en, xtal_en}, 3'b110);
            else        check("R3 crystal clock", {refsel_pad, u2ref_gate_en, xtal_en}, 3'b001);
            do_stop(p[0]);
            check("R14 err sticky after stop", err, (nto == 3) ? 1'b1 : 1'b0);
            repeat (3) tick();
            check("R14 err sticky while idle", err, (nto == 3) ? 1'b1 : 1'b0);
         end
      end

      // Read error other than timeout: no retry.
      set_rsp(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
      run_seq(1'b1, 1'b0, 1'b0, 1'b0);
      check("R10 read error single attempt", {n_rd[3:0], n_wr[3:0]}, 8'h10);
      check("R10 read error ends in fault", {ready, busy, err}, 3'b001);

      // Write error.
      cr_rdata = 16'h0001;
      set_rsp(2'b00, 2'b11, 2'b00, 2'b00, 2'b00);
      run_seq(1'b0, 1'b0, 1'b0, 1'b0);
      check("R10 write error", {n_rd[3:0], n_wr[3:0]}, 8'h11);
      check("R10 write error data", last_wdata, 16'h0341);
      check("R10 write error ends in fault", {ready, busy, err}, 3'b001);

      // Clean run, then start and stop in the same cycle: start wins.
      set_rsp(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      run_seq(1'b1, 1'b0, 1'b0, 1'b0);
      check("R11 ready before collision", ready, 1'b1);
      set_rsp(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      run_seq(1'b1, 1'b1, 1'b0, 1'b1);
      check("R13 start wins, run completes", {ready, err, rst_aux_n, rst_u3phy_n}, 4'b1011);

      // Stop while busy is ignored.
      set_rsp(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      run_seq(1'b0, 1'b0, 1'b1, 1'b1);
      check("R13 stop while busy ignored", {ready, rst_u3phy_n, rst_u2por_n, xtal_en}, 4'b1111);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests = n_tests + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule